// File: doc/BRIEF.md
# Fault-Tagged Instruction Prefetch Buffer

This block is a small first-in first-out queue that sits between the instruction fetch bus and the decoder. Each word the fetch bus returns is written together with its fetch address and a one-bit bus-error tag. A bus error on a prefetch raises nothing when the fetch completes. The error stays attached to the stored word.

The tag matters only when the decoder takes that word. If the entry is clean, the word is presented as an instruction. If the entry is tagged, the instruction is aborted: the instruction-valid output stays low and an access-error strobe is raised together with the faulting address. A change of program flow pulses the flush input. The flush empties the queue in one cycle, so tagged words that were prefetched but never consumed disappear with no exception.

The decoder sees a delivery one clock after it requests a word. It may request a word on every cycle.

Top module: `fault_prefetch_buf`

## Requirements
- R1: After a synchronous active-low reset, `buf_empty` is 1, `buf_full` is 0, `fill_ready` is 1, and both `out_valid` and `out_fault` are 0.
- R2: A fetch word is written when `fill_valid` is 1, the queue is not full and `flush` is 0. With DEPTH entries stored, `buf_full` is 1 and `fill_ready` is 0.
- R3: Words are delivered in the order they were written. A delivery appears on the outputs in the cycle after the clock edge at which `take` was sampled high with the queue non-empty and `flush` low.
- R4: Delivering a clean entry (tag 0) drives `out_valid`=1 and `out_fault`=0 for one cycle, with `out_word` and `out_addr` equal to the stored word and address.
- R5: Delivering a tagged entry (tag 1) drives `out_fault`=1 and `out_valid`=0 for one cycle, with `out_addr` equal to the stored fetch address. Writing a tagged word never raises `out_fault` by itself.
- R6: A flush empties the queue in one cycle. Tagged entries discarded by a flush never produce `out_fault`, and the next word written after the flush is the next one delivered.
- R7: When `flush` is high in the same cycle as `fill_valid` and/or `take`, the flush wins. No word is written, nothing is delivered in the next cycle, and the queue is empty afterwards.
- R8: `take` while the queue is empty produces no delivery (`out_valid`=0, `out_fault`=0) and leaves the queue empty.
- R9: `fill_valid` while the queue is full is ignored. The queue stays full, and the word offered is never delivered.
- R10: A write and a take in the same cycle, on a queue that is neither empty nor full, leave the occupancy unchanged and keep the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fill_valid | input | 1 | Fetch response present |
| fill_word | input | WORD_W | Fetched instruction word |
| fill_addr | input | ADDR_W | Address the word was fetched from |
| fill_err | input | 1 | Bus error on this fetch |
| fill_ready | output | 1 | Queue can accept a fetch word |
| take | input | 1 | Decoder requests the next word |
| flush | input | 1 | Change of flow: discard all entries |
| out_valid | output | 1 | Clean instruction word delivered |
| out_fault | output | 1 | Access error: delivered word was tagged |
| out_word | output | WORD_W | Delivered word |
| out_addr | output | ADDR_W | Address of the delivered word, or the faulting address |
| buf_full | output | 1 | All entries occupied |
| buf_empty | output | 1 | No entries occupied |

## Verification
A corrupted read or write pointer shows up on the very next delivery as a word or address out of order. A count that slips shows up as `buf_full` or `buf_empty` at the wrong occupancy within the same fill or drain. A tag that is lost, or that leaks past a flush, swaps `out_valid` and `out_fault` on the delivery one cycle after the take. The bench sweeps every error-tag pattern across a full queue, so a stuck or misplaced tag bit in any slot flips the outcome of at least one of those deliveries.

// File: rtl/pfb_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the fault-tagged prefetch buffer.
// Assumes: nothing beyond IEEE 1800-2017.
package pfb_pkg;
    // Outcome of one decoder take, held in the delivery register
    typedef enum logic [1:0] {
        DLV_NONE  = 2'd0,
        DLV_INSN  = 2'd1,
        DLV_FAULT = 2'd2
    } dlv_kind_t;
endpackage

// File: rtl/pfb_ctrl.sv
`timescale 1ns/1ps
// Module: pfb_ctrl
// Keeps the read and write pointers and the occupancy count. It turns the
// fill, take and flush requests into qualified write and read strobes.
// Assumes: flush has priority over both write and read in the same cycle.
module pfb_ctrl #(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_valid,
    input  logic             take,
    input  logic             flush,
    output logic             wr_en,
    output logic             rd_fire,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             full,
    output logic             empty
);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [CNT_W-1:0] cnt_q;

    // Status flags derived from the occupancy count
    always_comb begin
        full  = (cnt_q == CNT_MAX);
        empty = (cnt_q == '0);
    end

    // Qualified strobes; a flush blocks both write and read
    always_comb begin
        wr_en   = fill_valid && !full  && !flush;
        rd_fire = take       && !empty && !flush;
    end

    // Pointer and count update, cleared by reset or flush
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (wr_en) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (rd_fire) rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            case ({wr_en, rd_fire})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R2: occupancy never exceeds the depth
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);

    // R6: a flush leaves the queue empty on the next cycle
    assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

    // R10: a simultaneous write and read keep the occupancy
    assert_push_pop_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_fire) |=> $stable(cnt_q));
endmodule

// File: rtl/pfb_store.sv
`timescale 1ns/1ps
// Module: pfb_store
// Entry storage: one word, one fetch address and one error tag per slot.
// Writes go to the slot at wr_ptr. The slot at rd_ptr is always readable.
// Assumes: pointers come from pfb_ctrl and stay below DEPTH.
module pfb_store #(
    parameter int DEPTH  = 4,
    parameter int WORD_W = 16,
    parameter int ADDR_W = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_err,
    input  logic [PTR_W-1:0]  rd_ptr,
    output logic [WORD_W-1:0] rd_word,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_err
);
    logic [WORD_W-1:0] word_q [DEPTH];
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DEPTH-1:0]  tag_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Payload capture for slot g
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q[g] <= '0;
                addr_q[g] <= '0;
            end else if (wr_en && (wr_ptr == PTR_W'(g))) begin
                word_q[g] <= wr_word;
                addr_q[g] <= wr_addr;
            end
        end

        // Error tag for slot g; a flush scrubs it so no stale fault survives
        always_ff @(posedge clk) begin
            if (!rst_n || flush) tag_q[g] <= 1'b0;
            else if (wr_en && (wr_ptr == PTR_W'(g))) tag_q[g] <= wr_err;
        end
    end

    // Read port: the head slot chosen by rd_ptr
    always_comb begin
        rd_word = '0;
        rd_addr = '0;
        rd_err  = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_ptr == PTR_W'(i)) begin
                rd_word = word_q[i];
                rd_addr = addr_q[i];
                rd_err  = tag_q[i];
            end
        end
    end

    // R6: every tag is cleared one cycle after a flush
    assert_flush_scrubs_tags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> ($countones(tag_q) == 0));
endmodule

// File: rtl/pfb_deliver.sv
`timescale 1ns/1ps
// Module: pfb_deliver
// Delivery register. It turns a qualified read into either a clean
// instruction or an access error, each lasting one cycle.
// Assumes: rd_fire is already blocked by flush and by an empty queue.
module pfb_deliver
    import pfb_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_fire,
    input  logic [WORD_W-1:0] rd_word,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_err,
    output logic              out_valid,
    output logic              out_fault,
    output logic [WORD_W-1:0] out_word,
    output logic [ADDR_W-1:0] out_addr
);
    dlv_kind_t kind_q;

    // Classify each take: tagged entries become faults, others instructions
    always_ff @(posedge clk) begin
        if (!rst_n) kind_q <= DLV_NONE;
        else if (rd_fire) kind_q <= rd_err ? DLV_FAULT : DLV_INSN;
        else kind_q <= DLV_NONE;
    end

    // Hold the word and address of the most recent take
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_word <= '0;
            out_addr <= '0;
        end else if (rd_fire) begin
            out_word <= rd_word;
            out_addr <= rd_addr;
        end
    end

    // Port decode of the delivery kind
    always_comb begin
        out_valid = (kind_q == DLV_INSN);
        out_fault = (kind_q == DLV_FAULT);
    end

    // R5: a tagged take yields a fault and suppresses the instruction
    assert_tag_gives_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && rd_err) |=> (out_fault && !out_valid));

    // R4: a clean take yields the stored word and address
    assert_clean_gives_insn_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && !rd_err) |=> (out_valid && out_word == $past(rd_word)
                                  && out_addr == $past(rd_addr)));
endmodule

// File: rtl/fault_prefetch_buf.sv
`timescale 1ns/1ps
// Module: fault_prefetch_buf (top)
// Prefetch queue whose fetch bus errors travel with the word. An error is
// reported only when the decoder takes the word, and a flush discards it.
// Assumes: the fetch side honours fill_ready; flush marks a change of flow.
module fault_prefetch_buf #(
    parameter int DEPTH  = 4,
    parameter int WORD_W = 16,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_valid,
    input  logic [WORD_W-1:0] fill_word,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_err,
    output logic              fill_ready,
    input  logic              take,
    input  logic              flush,
    output logic              out_valid,
    output logic              out_fault,
    output logic [WORD_W-1:0] out_word,
    output logic [ADDR_W-1:0] out_addr,
    output logic              buf_full,
    output logic              buf_empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic             wr_en;
    logic             rd_fire;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [WORD_W-1:0] head_word;
    logic [ADDR_W-1:0] head_addr;
    logic              head_err;

    pfb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_valid (fill_valid),
        .take       (take),
        .flush      (flush),
        .wr_en      (wr_en),
        .rd_fire    (rd_fire),
        .wr_ptr     (wr_ptr),
        .rd_ptr     (rd_ptr),
        .full       (buf_full),
        .empty      (buf_empty)
    );

    pfb_store #(.DEPTH(DEPTH), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .wr_en   (wr_en),
        .wr_ptr  (wr_ptr),
        .wr_word (fill_word),
        .wr_addr (fill_addr),
        .wr_err  (fill_err),
        .rd_ptr  (rd_ptr),
        .rd_word (head_word),
        .rd_addr (head_addr),
        .rd_err  (head_err)
    );

    pfb_deliver #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_deliver (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_fire   (rd_fire),
        .rd_word   (head_word),
        .rd_addr   (head_addr),
        .rd_err    (head_err),
        .out_valid (out_valid),
        .out_fault (out_fault),
        .out_word  (out_word),
        .out_addr  (out_addr)
    );

    // Back-pressure toward the fetch bus
    always_comb fill_ready = !buf_full;

    // R7: a flush suppresses any delivery in the following cycle
    assert_flush_blocks_delivery_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!out_valid && !out_fault));

    // R8: a take on an empty queue delivers nothing
    assert_empty_take_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && buf_empty) |=> (!out_valid && !out_fault && buf_empty));

    // R9: a fill offered to a full queue changes nothing
    assert_full_fill_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && !take && !flush) |=> buf_full);

    // R5: fetch errors never surface without a take
    assert_no_fault_without_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> !out_fault);
endmodule

// File: tb/tb_fault_prefetch_buf.sv
`timescale 1ns/1ps
// Bench: sweeps every error-tag pattern over a full four-entry queue.
// It checks delivery order, fault reporting, flush discard and edge cases.
module tb_fault_prefetch_buf;
    localparam int DEPTH  = 4;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fill_valid = 1'b0;
    logic [WORD_W-1:0] fill_word = '0;
    logic [ADDR_W-1:0] fill_addr = '0;
    logic              fill_err = 1'b0;
    logic              fill_ready;
    logic              take = 1'b0;
    logic              flush = 1'b0;
    logic              out_valid;
    logic              out_fault;
    logic [WORD_W-1:0] out_word;
    logic [ADDR_W-1:0] out_addr;
    logic              buf_full;
    logic              buf_empty;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    fault_prefetch_buf #(.DEPTH(DEPTH), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_word(fill_word),
        .fill_addr(fill_addr), .fill_err(fill_err), .fill_ready(fill_ready),
        .take(take), .flush(flush), .out_valid(out_valid), .out_fault(out_fault),
        .out_word(out_word), .out_addr(out_addr), .buf_full(buf_full),
        .buf_empty(buf_empty)
    );

    always #10 clk = ~clk;

    // Advance one clock; inputs change and outputs are sampled 5 ns after the edge
    task automatic step();
        @(posedge clk);
        #5;
    endtask

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [WORD_W-1:0] wexp(input int pat, input int i);
        return WORD_W'(16'h4000 + pat * 256 + i * 17);
    endfunction

    function automatic logic [ADDR_W-1:0] aexp(input int pat, input int i);
        return ADDR_W'(32'h0001_0000 + pat * 64 + i * 2);
    endfunction

    task automatic offer(input logic [WORD_W-1:0] w, input logic [ADDR_W-1:0] a, input logic e);
        fill_valid = 1'b1; fill_word = w; fill_addr = a; fill_err = e;
    endtask

    task automatic idle();
        fill_valid = 1'b0; fill_err = 1'b0; take = 1'b0; flush = 1'b0;
    endtask

    // Check one delivery against the expected word, address and tag
    task automatic expect_dlv(input logic [WORD_W-1:0] w, input logic [ADDR_W-1:0] a, input logic e);
        if (e) begin
            check(out_fault && !out_valid, "R5 fault/valid", {out_fault, out_valid}, 2'b10);
            check(out_addr == a, "R5 fault addr", out_addr, a);
        end else begin
            check(out_valid && !out_fault, "R4 valid/fault", {out_valid, out_fault}, 2'b10);
            check(out_word == w, "R3 R4 word", out_word, w);
            check(out_addr == a, "R4 addr", out_addr, a);
        end
    endtask

    initial begin
        step(); step(); step();
        rst_n = 1'b1;
        // R1: state right after reset
        check(buf_empty == 1'b1, "R1 empty", buf_empty, 1);
        check(buf_full == 1'b0, "R1 full", buf_full, 0);
        check(fill_ready == 1'b1, "R1 ready", fill_ready, 1);
        check(!out_valid && !out_fault, "R1 outputs", {out_valid, out_fault}, 0);

        for (int pat = 0; pat < 16; pat++) begin
            // R2/R5: fill four words whose tags follow pat; no fault while filling
            for (int i = 0; i < DEPTH; i++) begin
                offer(wexp(pat, i), aexp(pat, i), pat[i]);
                step();
                check(!out_fault, "R5 no fault at fetch", out_fault, 0);
            end
            check(buf_full && !fill_ready, "R2 full", {buf_full, fill_ready}, 2'b10);
            // R9: extra word offered while full is dropped
            offer(16'hDEAD, 32'hBAD0, 1'b1);
            step();
            check(buf_full, "R9 still full", buf_full, 1);
            idle();
            // R3/R4/R5: drain in order
            take = 1'b1;
            for (int i = 0; i < DEPTH; i++) begin
                step();
                if (i == DEPTH - 1) take = 1'b0;
                expect_dlv(wexp(pat, i), aexp(pat, i), pat[i]);
            end
            check(buf_empty, "R3 empty after drain", buf_empty, 1);
            // R8: take on empty queue
            take = 1'b1;
            step();
            take = 1'b0;
            check(!out_valid && !out_fault && buf_empty, "R8 empty take",
                  {out_valid, out_fault, buf_empty}, 3'b001);

            // R6/R7: refill with tagged words, then flush against fill and take
            for (int i = 0; i < DEPTH - 1; i++) begin
                offer(wexp(pat, i), aexp(pat, i), 1'b1);
                step();
            end
            offer(16'hFFFF, 32'hF0F0, 1'b1);
            take = 1'b1;
            flush = 1'b1;
            step();
            idle();
            check(buf_empty && !out_valid && !out_fault, "R7 flush wins",
                  {buf_empty, out_valid, out_fault}, 3'b100);
            // R6: next word written after the flush is the next one delivered, clean
            offer(wexp(pat, 3) ^ 16'h0F0F, aexp(pat, 3) + 32'h100, 1'b0);
            step();
            idle();
            take = 1'b1;
            step();
            take = 1'b0;
            check(out_valid && !out_fault, "R6 no stale fault", {out_valid, out_fault}, 2'b10);
            check(out_word == (wexp(pat, 3) ^ 16'h0F0F), "R6 word after flush",
                  out_word, wexp(pat, 3) ^ 16'h0F0F);
            step();
            check(buf_empty && !out_fault, "R6 empty", {buf_empty, out_fault}, 2'b10);
        end

        // R10: simultaneous write and take on a partly filled queue
        offer(wexp(1, 0), aexp(1, 0), 1'b0); step();
        offer(wexp(1, 1), aexp(1, 1), 1'b1); step();
        offer(wexp(1, 2), aexp(1, 2), 1'b0);
        take = 1'b1;
        step();
        idle();
        expect_dlv(wexp(1, 0), aexp(1, 0), 1'b0);
        check(!buf_empty && !buf_full, "R10 occupancy kept", {buf_empty, buf_full}, 0);
        take = 1'b1;
        step();
        expect_dlv(wexp(1, 1), aexp(1, 1), 1'b1);
        step();
        take = 1'b0;
        expect_dlv(wexp(1, 2), aexp(1, 2), 1'b0);
        check(buf_empty, "R10 drained", buf_empty, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: ends a hung run as a failed check
    initial begin
        #4_000_000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule